// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Controller

This block keeps the replacement history for a configurable number of cache sets, each with a power-of-two number of ways (eight by default). A set needs only ways-minus-one history bits, arranged as a binary tree. Every bit covers a group of ways and marks which half of that group was used more recently. Exact LRU is avoided because its storage and update logic grow quickly once a set has more than four ways. With two ways the single bit gives exact LRU.

The surrounding cache reports each access with a set index and the way that hit or was filled. When it needs to allocate, it raises a query with a set index and a mask of the ways that hold no valid line. The block answers in the same cycle. It picks an empty way first; when the set is full it follows the tree bits from the root down to a leaf. Tag compare and data storage sit outside this block.

Top module: `plru_tree_ctrl`

## Requirements
- R1: After reset every tree bit of every set is zero, so a query on any set with an all-zero empty mask returns way 0.
- R2: An access to way w in set s changes only the bits on w's path from the root. Each of those bits is set to point at the half that does not contain w (1 when w lies in the lower-numbered half of that bit's group, 0 when it lies in the upper half). The change is visible from the next cycle onward.
- R3: With no empty ways, the victim is found by starting at the root bit and descending: bit value 0 goes to the lower-numbered half and 1 to the upper half, until one way remains. Bit n has children 2n+1 (lower half) and 2n+2 (upper half). Bit 0 splits ways 0-3 from 4-7, bits 1 and 2 split pairs, and bits 3 to 6 split single ways.
- R4: In a full set, the way accessed in one cycle is never the victim named for that set in the next cycle.
- R5: When the empty mask (bit i set means way i is empty) has any bit set, the victim is the lowest-numbered way whose bit is set, whatever the tree holds.
- R6: When an access and a query target the same set in the same cycle, the query answer uses the tree state from before that access.
- R7: An access to one set leaves the victim of every other set unchanged.
- R8: While qry_valid is low, vic_way reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | An access to record this cycle |
| upd_set | input | log2(NUM_SETS) | Set index of the access |
| upd_way | input | log2(NUM_WAYS) | Way that was accessed |
| qry_valid | input | 1 | Victim query this cycle |
| qry_set | input | log2(NUM_SETS) | Set index of the query |
| qry_empty | input | NUM_WAYS | Bit i set when way i holds no valid line |
| vic_way | output | log2(NUM_WAYS) | Victim way, same cycle as the query |

## Verification
The history update and the victim lookup can fall in the same cycle. The hard case is when both name the same set, because the answer must come from the old tree. The bench provokes this both in directed steps, with an access and a query on one fresh set in one cycle, and in a long random phase. That phase limits the index to four sets, so collisions happen often. Each cycle, a behavioural model that still holds the old state predicts the answer before it applies the access, and the answer is compared against that prediction.

// File: rtl/plru_pkg.sv
package plru_pkg;

   // Index width for a count of items; never narrower than one bit.
   function automatic int unsigned plru_idx_w(int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

   // True when a value is a power of two and at least one.
   function automatic bit plru_is_pow2(int unsigned value);
      return (value != 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/plru_state_array.sv
// Per-set tree storage: one write port, two asynchronous read ports.
module plru_state_array #(
   parameter int unsigned NUM_SETS  = 16,
   parameter int unsigned TREE_BITS = 7,
   parameter int unsigned SET_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SET_W-1:0]     wr_set,
   input  logic [TREE_BITS-1:0] wr_bits,
   input  logic [SET_W-1:0]     rd_a_set,
   output logic [TREE_BITS-1:0] rd_a_bits,
   input  logic [SET_W-1:0]     rd_b_set,
   output logic [TREE_BITS-1:0] rd_b_bits
);

   logic [TREE_BITS-1:0] tree_q [NUM_SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            tree_q[s] <= '0;
         end
      end else if (wr_en) begin
         tree_q[wr_set] <= wr_bits;
      end
   end

   assign rd_a_bits = tree_q[rd_a_set];
   assign rd_b_bits = tree_q[rd_b_set];

endmodule

// File: rtl/plru_path_update.sv
// Points every tree bit on the accessed way's path away from that way.
module plru_path_update #(
   parameter int unsigned NUM_WAYS = 8,
   parameter int unsigned WAY_W    = 3
) (
   input  logic [NUM_WAYS-2:0] old_bits,
   input  logic [WAY_W-1:0]    way,
   output logic [NUM_WAYS-2:0] new_bits
);

   for (genvar lv = 0; lv < WAY_W; lv++) begin : g_level
      // Upper lv bits of the way select the node within this level.
      logic [WAY_W-1:0] prefix;
      assign prefix = way >> (WAY_W - lv);
      for (genvar k = 0; k < (1 << lv); k++) begin : g_node
         localparam int unsigned NODE = (1 << lv) - 1 + k;
         localparam logic [WAY_W-1:0] KEY = WAY_W'(k);
         assign new_bits[NODE] = (prefix == KEY) ? ~way[WAY_W-1-lv]
                                                 : old_bits[NODE];
      end
   end

endmodule

// File: rtl/plru_victim_walk.sv
// Descends from the root: 0 picks the lower half, 1 the upper half.
module plru_victim_walk #(
   parameter int unsigned NUM_WAYS = 8,
   parameter int unsigned WAY_W    = 3
) (
   input  logic [NUM_WAYS-2:0] bits,
   output logic [WAY_W-1:0]    way
);

   always_comb begin
      logic [WAY_W-1:0] prefix;
      int unsigned      node;
      prefix = '0;
      for (int unsigned lv = 0; lv < WAY_W; lv++) begin
         node   = (32'd1 << lv) - 32'd1 + 32'(prefix);
         prefix = (prefix << 1) | WAY_W'(bits[node]);
      end
      way = prefix;
   end

endmodule

// File: rtl/plru_empty_pick.sv
// Lowest-numbered set bit of the empty-way mask.
module plru_empty_pick #(
   parameter int unsigned NUM_WAYS = 8,
   parameter int unsigned WAY_W    = 3
) (
   input  logic [NUM_WAYS-1:0] mask,
   output logic                found,
   output logic [WAY_W-1:0]    idx
);

   always_comb begin
      idx = '0;
      for (int i = NUM_WAYS - 1; i >= 0; i--) begin
         if (mask[i]) idx = WAY_W'(i);
      end
   end

   assign found = |mask;

endmodule

// File: rtl/plru_tree_ctrl.sv
module plru_tree_ctrl
   import plru_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 8,
   parameter int unsigned NUM_SETS = 16,
   localparam int unsigned WAY_W     = plru_idx_w(NUM_WAYS),
   localparam int unsigned SET_W     = plru_idx_w(NUM_SETS),
   localparam int unsigned TREE_BITS = NUM_WAYS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_valid,
   input  logic [SET_W-1:0]    upd_set,
   input  logic [WAY_W-1:0]    upd_way,
   input  logic                qry_valid,
   input  logic [SET_W-1:0]    qry_set,
   input  logic [NUM_WAYS-1:0] qry_empty,
   output logic [WAY_W-1:0]    vic_way
);

   // Elaboration-time parameter checks.
   if ((NUM_WAYS < 2) || !plru_is_pow2(NUM_WAYS)) begin : g_bad_ways
      $error("plru_tree_ctrl: NUM_WAYS must be a power of two, at least 2");
   end
   if (!plru_is_pow2(NUM_SETS)) begin : g_bad_sets
      $error("plru_tree_ctrl: NUM_SETS must be a power of two");
   end

   logic [TREE_BITS-1:0] upd_old_bits;
   logic [TREE_BITS-1:0] upd_new_bits;
   logic [TREE_BITS-1:0] qry_bits;
   logic [WAY_W-1:0]     tree_way;
   logic [WAY_W-1:0]     empty_way;
   logic                 empty_found;

   plru_state_array #(
      .NUM_SETS  (NUM_SETS),
      .TREE_BITS (TREE_BITS),
      .SET_W     (SET_W)
   ) state_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (upd_valid),
      .wr_set    (upd_set),
      .wr_bits   (upd_new_bits),
      .rd_a_set  (upd_set),
      .rd_a_bits (upd_old_bits),
      .rd_b_set  (qry_set),
      .rd_b_bits (qry_bits)
   );

   plru_path_update #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
   ) update_i (
      .old_bits (upd_old_bits),
      .way      (upd_way),
      .new_bits (upd_new_bits)
   );

   plru_victim_walk #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
   ) walk_i (
      .bits (qry_bits),
      .way  (tree_way)
   );

   plru_empty_pick #(
      .NUM_WAYS (NUM_WAYS),
      .WAY_W    (WAY_W)
   ) empty_i (
      .mask  (qry_empty),
      .found (empty_found),
      .idx   (empty_way)
   );

   always_comb begin
      if (!qry_valid)       vic_way = '0;
      else if (empty_found) vic_way = empty_way;
      else                  vic_way = tree_way;
   end

endmodule

// File: rtl/plru_tree_ctrl_chk.sv
module plru_tree_ctrl_chk
   import plru_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 8,
   parameter int unsigned NUM_SETS = 16,
   localparam int unsigned WAY_W = plru_idx_w(NUM_WAYS),
   localparam int unsigned SET_W = plru_idx_w(NUM_SETS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                upd_valid,
   input logic [SET_W-1:0]    upd_set,
   input logic [WAY_W-1:0]    upd_way,
   input logic                qry_valid,
   input logic [SET_W-1:0]    qry_set,
   input logic [NUM_WAYS-1:0] qry_empty,
   input logic [WAY_W-1:0]    vic_way
);

   // R1: first cycle out of reset, a full set yields way 0.
   a_r1_reset_way0: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && qry_valid && (qry_empty == '0)) |-> (vic_way == '0));

   // R4: the way just accessed is not the next victim of its full set.
   a_r4_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(upd_valid) && qry_valid && (qry_set == $past(upd_set))
       && (qry_empty == '0)) |-> (vic_way != $past(upd_way)));

   // R5: an empty way wins, and it is the lowest-numbered one.
   a_r5_lowest_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && (qry_empty != '0)) |->
      (qry_empty[vic_way] &&
       ((qry_empty & ((NUM_WAYS'(1) << vic_way) - NUM_WAYS'(1))) == '0)));

   // R7: with no access to the queried set, its victim does not move.
   a_r7_set_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && qry_valid && $past(qry_valid) && (qry_set == $past(qry_set))
       && (qry_empty == '0) && ($past(qry_empty) == '0)
       && (!$past(upd_valid) || ($past(upd_set) != qry_set)))
      |-> $stable(vic_way));

   // R8: idle query reads zero.
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_valid |-> (vic_way == '0));

endmodule

bind plru_tree_ctrl plru_tree_ctrl_chk #(
   .NUM_WAYS (NUM_WAYS),
   .NUM_SETS (NUM_SETS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_valid (upd_valid),
   .upd_set   (upd_set),
   .upd_way   (upd_way),
   .qry_valid (qry_valid),
   .qry_set   (qry_set),
   .qry_empty (qry_empty),
   .vic_way   (vic_way)
);

// File: tb/plru_tree_ctrl_tb_top.sv
`timescale 1ns/1ps
module plru_tree_ctrl_tb_top;

   localparam int WAYS = 8;
   localparam int SETS = 16;
   localparam int TBIT = WAYS - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_valid = 1'b0;
   logic [3:0] upd_set = '0;
   logic [2:0] upd_way = '0;
   logic       qry_valid = 1'b0;
   logic [3:0] qry_set = '0;
   logic [7:0] qry_empty = '0;
   logic [2:0] vic_way;

   int n_tests = 0;
   int n_fail  = 0;
   int ref_bit [SETS][TBIT];

   always #2 clk = ~clk;

   plru_tree_ctrl #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_valid (upd_valid),
      .upd_set   (upd_set),
      .upd_way   (upd_way),
      .qry_valid (qry_valid),
      .qry_set   (qry_set),
      .qry_empty (qry_empty),
      .vic_way   (vic_way)
   );

   // Behavioural model: range halving over the way numbers.
   function automatic int model_victim(int s, logic [7:0] emp, bit qv);
      int lo, hi, n, mid;
      if (!qv) return 0;
      for (int i = 0; i < WAYS; i++) if (emp[i]) return i;
      lo = 0; hi = WAYS; n = 0;
      while (hi - lo > 1) begin
         mid = (lo + hi) / 2;
         if (ref_bit[s][n] == 0) begin hi = mid; n = 2*n + 1; end
         else begin lo = mid; n = 2*n + 2; end
      end
      return lo;
   endfunction

   function automatic void model_touch(int s, int w);
      int lo, hi, n, mid;
      lo = 0; hi = WAYS; n = 0;
      while (hi - lo > 1) begin
         mid = (lo + hi) / 2;
         if (w < mid) begin ref_bit[s][n] = 1; hi = mid; n = 2*n + 1; end
         else begin ref_bit[s][n] = 0; lo = mid; n = 2*n + 2; end
      end
   endfunction

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: vic_way=%0d expected %0d", req, act, exp);
      end
   endtask

   // One clock: drive at negedge, compare model, apply access after posedge.
   task automatic step(bit uv, int us, int uw, bit qv, int qs, logic [7:0] qe,
                       string req, int directed);
      int exp;
      @(negedge clk);
      upd_valid = uv; upd_set = 4'(us); upd_way = 3'(uw);
      qry_valid = qv; qry_set = 4'(qs); qry_empty = qe;
      #1;
      exp = model_victim(qs, qe, qv);
      check(req, int'(vic_way), exp);
      if (directed >= 0) check(req, int'(vic_way), directed);
      @(posedge clk);
      if (uv) model_touch(us, uw);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int b = 0; b < TBIT; b++) ref_bit[s][b] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every set starts with way 0 as victim
      for (int s = 0; s < SETS; s++) step(0, 0, 0, 1, s, 8'h00, "R1 reset", 0);

      // R8: idle query gives 0 even with a mask present
      step(0, 0, 0, 0, 2, 8'h10, "R8 idle", 0);

      // R2: access way 0 of set 3, victim moves to way 4
      step(1, 3, 0, 0, 0, 8'h00, "R2 access", -1);
      step(0, 0, 0, 1, 3, 8'h00, "R2 path away", 4);
      // R3: then way 4 accessed, walk lands on way 2
      step(1, 3, 4, 0, 0, 8'h00, "R3 access", -1);
      step(0, 0, 0, 1, 3, 8'h00, "R3 walk", 2);

      // R5: empty ways override the tree
      step(0, 0, 0, 1, 3, 8'b0010_1000, "R5 mask 0x28", 3);
      step(0, 0, 0, 1, 3, 8'h80, "R5 mask 0x80", 7);
      step(0, 0, 0, 1, 3, 8'hFF, "R5 mask 0xFF", 0);

      // R6: same-cycle access and query on fresh set 7 see old state
      step(1, 7, 0, 1, 7, 8'h00, "R6 collide", 0);
      step(0, 0, 0, 1, 7, 8'h00, "R6 after", 4);

      // R7: access set 5, set 6 unchanged
      step(1, 5, 0, 1, 6, 8'h00, "R7 other set", 0);
      step(0, 0, 0, 1, 6, 8'h00, "R7 other set after", 0);
      step(0, 0, 0, 1, 5, 8'h00, "R7 own set", 4);

      // R4: each way of set 9 in turn is not the next victim; sweep ends on way 0
      for (int w = 0; w < WAYS; w++) begin
         step(1, 9, w, 0, 0, 8'h00, "R4 access", -1);
         n_tests++;
         @(negedge clk);
         upd_valid = 0; qry_valid = 1; qry_set = 4'd9; qry_empty = '0;
         #1;
         if (int'(vic_way) == w) begin
            n_fail++;
            $display("FAIL R4: vic_way=%0d expected not %0d", vic_way, w);
         end
         @(posedge clk);
      end
      step(0, 0, 0, 1, 9, 8'h00, "R2 sweep end", 0);

      // Random phase over four sets for frequent collisions (R2 R3 R5 R6)
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom);
         step(r[0], (r >> 1) & 3, (r >> 3) & 7, r[6], (r >> 7) & 3,
              (((r >> 9) & 3) == 0) ? 8'((r >> 12) & 8'hFF) : 8'h00,
              "R2/R3/R5/R6 random", -1);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule